// File: doc/BRIEF.md
# Coherent Pulse-Width Capture Channel

This block is one input-capture channel of a timer. It watches an already filtered input signal and timestamps its edges against a free-running counter bus that comes from outside. A polarity control picks which input edge starts a pulse (the leading edge); the other edge ends it (the trailing edge). The leading edge parks the counter value in a staging register. The trailing edge records the counter value as the end time, and at the same moment moves the parked start time next to it. The end time and the start time that goes with it therefore always stay together as a pair.

Software reads the result through a two-register read port. The A register returns the latest end time. The B register returns a start time. Reading A snapshots the start time that matches that end time into the B holding register and freezes it, so a later read of B returns the partner of the A value already read. Reading B releases the freeze. An event flag is raised at each trailing-edge capture and is cleared by writing 1. A width output gives the end time minus the held start time.

Top module: `pwcap_channel`

## Requirements
- R1: After reset the event flag is 0, every capture register reads 0 (rdData is 0 for both rdSel values and pulseWidth is 0), and the start-time holding register is unlocked.
- R2: With leadPol = 1 a rising edge of sigIn is the leading edge and a falling edge is the trailing edge. With leadPol = 0 the roles are swapped.
- R3: A leading edge stores cntBus in the staging register. A leading edge neither sets the flag nor changes any readable value.
- R4: A trailing edge stores cntBus as the end time and copies the staging register into the paired start register. This copy happens whether or not the holding register is locked. When the holding register is unlocked, the same edge also copies the staging register into it.
- R5: A read with rdSel = 0 (A register) returns the end time on rdData in the same cycle. In that clock, it loads the holding register from the paired start register and sets the lock.
- R6: While the holding register is locked, trailing edges leave it unchanged. A further A-register read still reloads it from the paired start register.
- R7: A read with rdSel = 1 (B register) returns the holding register in the same cycle. It reloads the holding register from the paired start register and clears the lock. Copies from the staging register resume at the next trailing edge.
- R8: An input change on sigIn is captured at the third rising clock edge after it is applied (two synchronizer stages plus the edge-compare stage). The flag rises at that edge when the change is a trailing edge.
- R9: A cycle with flagClr = 1 clears the flag. If a trailing-edge capture occurs in the same cycle, the flag is set instead.
- R10: pulseWidth equals the end time minus the holding register, modulo 2^24.
- R11: When a read and a trailing-edge capture fall in the same clock, the read decides the holding register. It is loaded from the paired start register as it stood before the capture, and the capture's staging copy into it is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sigIn | input | 1 | Filtered input signal to be measured |
| cntBus | input | 24 | Free-running counter value |
| leadPol | input | 1 | 1: rising edge is leading; 0: falling edge is leading |
| rdEn | input | 1 | Read strobe, one cycle per access |
| rdSel | input | 1 | 0 selects the A (end time) register, 1 the B (start time) register |
| flagClr | input | 1 | Write-one-to-clear strobe for the event flag |
| rdData | output | 24 | Read data of the selected register, combinational |
| pulseWidth | output | 24 | End time minus held start time, wrapping |
| eventFlag | output | 1 | Set at each trailing-edge capture |

## Verification
A change on sigIn takes effect at the third rising clock edge after it is driven. The bench drives sigIn on a falling edge, holds cntBus steady across those three edges, and samples the flag and the width on the falling edge that follows the third. One test probes the flag after the second and after the third edge to pin down this latency. Read data is combinational: the bench samples it while rdEn is high, before the edge that applies the read's side effects, and observes those effects only after that edge. The same-cycle cases, a read or a flag clear coinciding with a capture, place the strobe in the falling-edge window just before the third edge.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;

  // Strobes from control to datapath, valid for one clock.
  typedef struct packed {
    logic capLead;   // store counter into staging register
    logic capTrail;  // store counter into end time, staging into paired start
    logic b2ToB1;    // staging register into holding register
    logic b1FromA1;  // paired start into holding register (read side effect)
  } pwStrobes_t;

endpackage

// File: rtl/pwcap_edge.sv
module pwcap_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  input  logic leadPol,
  output logic leadEvt,
  output logic trailEvt
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          prevQ;
  logic          rise;
  logic          fall;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= sigIn;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[LAST-1:0], sigIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[LAST];
  end

  assign rise = syncQ[LAST] & ~prevQ;
  assign fall = ~syncQ[LAST] & prevQ;

  always_comb begin
    leadEvt  = leadPol ? rise : fall;
    trailEvt = leadPol ? fall : rise;
  end

  // R2: leading and trailing edges are never reported together
  a_r2_one_edge: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({leadEvt, trailEvt}));

endmodule

// File: rtl/pwcap_ctrl.sv
module pwcap_ctrl
  import pwcap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       leadEvt,
  input  logic       trailEvt,
  input  logic       rdEn,
  input  logic       rdSel,
  input  logic       flagClr,
  output pwStrobes_t strb,
  output logic       eventFlag
);

  logic locked;
  logic rdA;
  logic rdB;

  assign rdA = rdEn & ~rdSel;
  assign rdB = rdEn & rdSel;

  always_comb begin
    strb          = '0;
    strb.capLead  = leadEvt;
    strb.capTrail = trailEvt;
    strb.b1FromA1 = rdEn;
    strb.b2ToB1   = trailEvt & ~locked & ~rdEn;
  end

  // Lock on A read, release on B read.
  always_ff @(posedge clk) begin
    if (!rstN)    locked <= 1'b0;
    else if (rdA) locked <= 1'b1;
    else if (rdB) locked <= 1'b0;
  end

  // Flag: set beats clear.
  always_ff @(posedge clk) begin
    if (!rstN)         eventFlag <= 1'b0;
    else if (trailEvt) eventFlag <= 1'b1;
    else if (flagClr)  eventFlag <= 1'b0;
  end

  // R5: an A read leaves the holding register locked
  a_r5_lock_on_a: assert property (@(posedge clk) disable iff (!rstN)
    rdA |=> locked);

  // R7: a B read releases the lock
  a_r7_unlock_on_b: assert property (@(posedge clk) disable iff (!rstN)
    rdB |=> !locked);

  // R6: no staging copy while locked
  a_r6_no_copy_locked: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !strb.b2ToB1);

  // R9: a capture in the same cycle as a clear leaves the flag set
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (trailEvt && flagClr) |=> eventFlag);

  // R9: a clear with no capture drops the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !trailEvt) |=> !eventFlag);

endmodule

// File: rtl/pwcap_datapath.sv
module pwcap_datapath
  import pwcap_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwStrobes_t       strb,
  input  logic [CNT_W-1:0] cntBus,
  input  logic             rdSel,
  output logic [CNT_W-1:0] rdData,
  output logic [CNT_W-1:0] pulseWidth
);

  logic [CNT_W-1:0] stageLead;  // staging start time
  logic [CNT_W-1:0] pairStart;  // start paired with endTime
  logic [CNT_W-1:0] endTime;    // latest end time
  logic [CNT_W-1:0] holdStart;  // software-visible start time

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageLead <= '0;
      pairStart <= '0;
      endTime   <= '0;
    end else begin
      if (strb.capLead) stageLead <= cntBus;
      if (strb.capTrail) begin
        endTime   <= cntBus;
        pairStart <= stageLead;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              holdStart <= '0;
    else if (strb.b1FromA1) holdStart <= pairStart;
    else if (strb.b2ToB1)   holdStart <= stageLead;
  end

  assign rdData     = rdSel ? holdStart : endTime;
  assign pulseWidth = endTime - holdStart;

  // R4: every trailing capture moves the staging value to the pair register
  a_r4_pair_move: assert property (@(posedge clk) disable iff (!rstN)
    strb.capTrail |=> (pairStart == $past(stageLead)));

  // R11: a read wins the holding register over a same-cycle capture
  a_r11_read_priority: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capTrail && strb.b1FromA1) |=> (holdStart == $past(pairStart)));

  // R3: a leading edge leaves the end time alone
  a_r3_lead_keeps_end: assert property (@(posedge clk) disable iff (!rstN)
    strb.capLead |=> $stable(endTime));

endmodule

// File: rtl/pwcap_channel.sv
module pwcap_channel
  import pwcap_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sigIn,
  input  logic [CNT_W-1:0] cntBus,
  input  logic             leadPol,
  input  logic             rdEn,
  input  logic             rdSel,
  input  logic             flagClr,
  output logic [CNT_W-1:0] rdData,
  output logic [CNT_W-1:0] pulseWidth,
  output logic             eventFlag
);

  pwStrobes_t strb;
  logic       leadEvt;
  logic       trailEvt;

  pwcap_edge #(.SYNC_STAGES(SYNC_STAGES)) uEdge (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .leadPol(leadPol),
    .leadEvt(leadEvt), .trailEvt(trailEvt)
  );

  pwcap_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .leadEvt(leadEvt), .trailEvt(trailEvt),
    .rdEn(rdEn), .rdSel(rdSel), .flagClr(flagClr),
    .strb(strb), .eventFlag(eventFlag)
  );

  pwcap_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .cntBus(cntBus), .rdSel(rdSel),
    .rdData(rdData), .pulseWidth(pulseWidth)
  );

endmodule

// File: tb/tb_pwcap_channel.sv
module tb_pwcap_channel;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sigIn = 1'b0;
  logic [23:0] cntBus = '0;
  logic        leadPol = 1'b1;
  logic        rdEn = 1'b0;
  logic        rdSel = 1'b0;
  logic        flagClr = 1'b0;
  logic [23:0] rdData;
  logic [23:0] pulseWidth;
  logic        eventFlag;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  // model of the requirements
  logic [23:0] mStage, mPair, mEnd, mHold;
  logic        mLocked, mFlag;

  always #2.5 clk = ~clk;

  pwcap_channel dut (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .cntBus(cntBus), .leadPol(leadPol),
    .rdEn(rdEn), .rdSel(rdSel), .flagClr(flagClr),
    .rdData(rdData), .pulseWidth(pulseWidth), .eventFlag(eventFlag)
  );

  task automatic check(input bit ok, input string req, input logic [23:0] act,
                       input logic [23:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%06h expected 0x%06h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mStage = '0; mPair = '0; mEnd = '0; mHold = '0; mLocked = 0; mFlag = 0;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 0; sigIn = 0; rdEn = 0; flagClr = 0; leadPol = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    modelReset();
  endtask

  task automatic modelEdge(input logic level, input logic [23:0] cnt);
    if (level == leadPol) mStage = cnt;
    else begin
      mEnd = cnt; mPair = mStage;
      if (!mLocked) mHold = mStage;
      mFlag = 1;
    end
  endtask

  // drive a new level, wait until captured (third rising edge)
  task automatic edgeTo(input logic level, input logic [23:0] cnt);
    @(negedge clk);
    cntBus = cnt; sigIn = level;
    repeat (3) @(posedge clk);
    @(negedge clk);
    modelEdge(level, cnt);
  endtask

  task automatic doRead(input logic sel, input string req);
    @(negedge clk);
    rdEn = 1; rdSel = sel;
    #1;
    check(rdData == (sel ? mHold : mEnd), req, rdData, sel ? mHold : mEnd);
    @(negedge clk);
    rdEn = 0; rdSel = 0;
    mHold = mPair; mLocked = !sel;
  endtask

  task automatic checkWidth(input string req);
    check(pulseWidth == mEnd - mHold, req, pulseWidth, mEnd - mHold);
  endtask

  task automatic checkFlag(input string req);
    check(eventFlag == mFlag, req, {23'd0, eventFlag}, {23'd0, mFlag});
  endtask

  task automatic clearFlag();
    @(negedge clk); flagClr = 1;
    @(negedge clk); flagClr = 0; mFlag = 0;
  endtask

  task automatic testReset();
    applyReset();
    checkFlag("R1 flag");
    rdSel = 0; #1 check(rdData == 0, "R1 A reg", rdData, 0);
    rdSel = 1; #1 check(rdData == 0, "R1 B reg", rdData, 0);
    rdSel = 0;
    check(pulseWidth == 0, "R1 width", pulseWidth, 0);
  endtask

  task automatic testBasic();
    edgeTo(1, 24'h001000);
    checkFlag("R3 leading edge leaves flag");
    check(rdData == 0, "R3 leading edge leaves A reg", rdData, 0);
    edgeTo(0, 24'h001100);
    checkFlag("R4 trailing sets flag");
    checkWidth("R10 width 0x100");
    doRead(0, "R5 A read returns end time");
    doRead(1, "R7 B read returns start");
    clearFlag();
    checkFlag("R9 flag cleared");
  endtask

  task automatic testLock();
    edgeTo(1, 24'h001250);
    edgeTo(0, 24'h001525);
    doRead(0, "R5 A read");
    edgeTo(1, 24'h0016A0);
    edgeTo(0, 24'h001800);
    checkWidth("R6 holding frozen while locked");
    doRead(0, "R6 second A read");
    checkWidth("R6 reload from pair");
    doRead(1, "R7 B read returns partner");
    edgeTo(1, 24'h002000);
    edgeTo(0, 24'h002010);
    checkWidth("R7 copy resumes after unlock");
    check(pulseWidth == 24'h10, "R7 width 0x10", pulseWidth, 24'h10);
    clearFlag();
  endtask

  task automatic testLatency();
    @(negedge clk); cntBus = 24'h003000; sigIn = 1;
    repeat (3) @(posedge clk); @(negedge clk); modelEdge(1, 24'h003000);
    @(negedge clk); cntBus = 24'h003333; sigIn = 0;
    repeat (2) @(posedge clk); @(negedge clk);
    check(eventFlag == 0, "R8 not yet at second edge", {23'd0, eventFlag}, 0);
    @(posedge clk); @(negedge clk);
    modelEdge(0, 24'h003333);
    check(eventFlag == 1, "R8 flag at third edge", {23'd0, eventFlag}, 1);
    clearFlag();
  endtask

  task automatic testSetWins();
    edgeTo(1, 24'h004000);
    @(negedge clk); cntBus = 24'h004400; sigIn = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    flagClr = 1;
    @(posedge clk); @(negedge clk);
    flagClr = 0;
    modelEdge(0, 24'h004400);
    checkFlag("R9 set wins over clear");
    clearFlag();
    checkFlag("R9 clear afterwards");
  endtask

  task automatic testWrap();
    edgeTo(1, 24'hFFFFF0);
    edgeTo(0, 24'h000010);
    check(pulseWidth == 24'h20, "R10 wrap", pulseWidth, 24'h20);
    clearFlag();
  endtask

  task automatic testPolarity();
    leadPol = 0;
    edgeTo(1, 24'h000300);           // rising is trailing now
    checkFlag("R2 rising is trailing");
    clearFlag();
    edgeTo(0, 24'h000400);           // falling is leading
    checkFlag("R2 falling is leading");
    edgeTo(1, 24'h000480);
    check(pulseWidth == 24'h80, "R2 width with swapped roles", pulseWidth, 24'h80);
    doRead(1, "R2 B read");
    clearFlag();
    edgeTo(0, 24'h000500);           // back to low idle as leading
    leadPol = 1;
  endtask

  task automatic testSameCycle();
    logic [23:0] oldPair;
    edgeTo(1, 24'h005000);
    oldPair = mPair;
    @(negedge clk); cntBus = 24'h005555; sigIn = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rdEn = 1; rdSel = 0;
    #1 check(rdData == mEnd, "R11 A read in capture cycle", rdData, mEnd);
    @(posedge clk); @(negedge clk);
    rdEn = 0;
    mHold = oldPair; mLocked = 1;
    mEnd = 24'h005555; mPair = mStage; mFlag = 1;
    rdSel = 1; #1
    check(rdData == oldPair, "R11 holding took pre-capture pair", rdData, oldPair);
    rdSel = 0;
    doRead(1, "R11 B read after");
    clearFlag();
  endtask

  initial begin
    testReset();
    testBasic();
    testLock();
    testLatency();
    testSetWins();
    testWrap();
    testPolarity();
    testSameCycle();
    edgeTo(1, 24'h006000);
    edgeTo(0, 24'h006100);
    testReset();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nRun++; nFail++;
      $display("FAIL watchdog: actual 0x%06h expected 0x%06h", 24'd1, 24'd0);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule